// File: doc/BRIEF.md
# Sequential Unsigned Restoring Divider

This block divides one 32-bit unsigned number by another over many clock cycles. It produces a 32-bit quotient and a 32-bit remainder. A one-cycle `start` pulse captures both operands while the block is idle. The block then raises `busy` and spends one cycle on each quotient bit. When the last bit is done, it pulses `done` for one cycle and `busy` drops in that same cycle.

The working state is a double-width register pair. The upper half holds the partial remainder and the lower half holds the dividend, which the quotient gradually replaces. Each cycle does three things:

- It rotates the whole pair left by one place.
- It compares the upper half, widened by the bit rotated out of the top, against the divisor.
- It subtracts the divisor when the upper half is not smaller.

The raw "smaller than" result of the compare goes straight into the freed low bit, so the lower half collects the complement of the quotient. A single inversion at the end recovers the true quotient.

A zero divisor gets no special handling inside the loop. It naturally yields an all-ones quotient and a remainder equal to the dividend, and a status flag reports the case.

Top module: `seq_divider`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `busy`, `done`, `quotient`, `remainder` and `div_by_zero` are all 0.
- R2: A `start` sampled high while `busy` is low captures `dividend` and `divisor`. `busy` is high from the next cycle for exactly 32 cycles.
- R3: `done` is high for exactly one cycle, which is the cycle right after the 32nd busy cycle. `busy` is low whenever `done` is high.
- R4: In the `done` cycle with a nonzero divisor, `quotient` equals floor(dividend / divisor) and `remainder` equals dividend mod divisor. This holds for a divisor larger than the dividend, and for a divisor with bit 31 set, where the widened compare keeps the shifted-out bit.
- R5: With a zero divisor, the `done` cycle shows `quotient` = 0xFFFFFFFF, `remainder` = the dividend, and `div_by_zero` = 1. For a nonzero divisor, `div_by_zero` is 0 in the `done` cycle.
- R6: A `start` pulse while `busy` is high is ignored. The running operation keeps its operands and its timing.
- R7: A `start` sampled in the `done` cycle begins a new operation at once.
- R8: `quotient`, `remainder` and `div_by_zero` change only in a `done` cycle. They hold their values through a following operation until its own `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a division (honoured only while not busy) |
| dividend | input | 32 | Unsigned dividend, sampled with start |
| divisor | input | 32 | Unsigned divisor, sampled with start |
| busy | output | 1 | Iterations in progress |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | 32 | Quotient of the last completed division |
| remainder | output | 32 | Remainder of the last completed division |
| div_by_zero | output | 1 | Last completed division had a zero divisor |

## Verification
Two events can fall in the same cycle: a completion (`done` high, results being published) and acceptance of a new `start`. The bench provokes this by holding `start` high in exactly the cycle it sees `done`. The behavioural model then expects the following, each compared every cycle:

- the old results stay visible until the new `done`;
- `busy` returns one cycle later;
- the second division completes 33 cycles after the first.

A second overlap, a `start` arriving in mid-run, is judged by confirming that the running result and its timing are unchanged.

// File: rtl/div_pkg.sv
package div_pkg;

    // Default operand width of the divider
    localparam int DIV_W = 32;

    // Controller states
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } div_state_e;

endpackage

// File: rtl/div_step.sv
// One restoring iteration: rotate the pair, compare, conditionally subtract.
// The freed low bit receives the raw "less than" result (complemented quotient bit).
module div_step #(
    parameter int W = div_pkg::DIV_W
) (
    input  logic [W-1:0] rem_in,
    input  logic [W-1:0] quo_in,
    input  logic [W-1:0] dvsr,
    output logic [W-1:0] rem_out,
    output logic [W-1:0] quo_out
);
    logic         top_bit;
    logic [W-1:0] rem_sh;
    logic [W-1:0] sub_res;
    logic         below;

    always_comb begin
        top_bit = rem_in[W-1];
        rem_sh  = {rem_in[W-2:0], quo_in[W-1]};
        // widened compare keeps the bit rotated out of the top
        below   = ({top_bit, rem_sh} < {1'b0, dvsr});
        sub_res = rem_sh - dvsr;
        rem_out = below ? rem_sh : sub_res;
        quo_out = {quo_in[W-2:0], below};
    end
endmodule

// File: rtl/div_ctrl.sv
// Sequencer: idle/run state, iteration counter, handshake outputs.
module div_ctrl #(
    parameter int W  = div_pkg::DIV_W,
    parameter int CW = $clog2(W)
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic load,
    output logic step,
    output logic finish,
    output logic busy,
    output logic done
);
    import div_pkg::*;

    localparam logic [CW-1:0] LAST = CW'(W - 1);

    div_state_e    state_q;
    logic [CW-1:0] cnt_q;

    always_comb begin
        load   = (state_q == ST_IDLE) && start;
        step   = (state_q == ST_RUN);
        finish = step && (cnt_q == LAST);
        busy   = step;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            done    <= 1'b0;
        end else begin
            done <= finish;
            if (load) begin
                state_q <= ST_RUN;
                cnt_q   <= '0;
            end else if (finish) begin
                state_q <= ST_IDLE;
            end else if (step) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/div_result.sv
// Result registers: invert collected compare bits once and hold until next finish.
module div_result #(
    parameter int W = div_pkg::DIV_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         finish,
    input  logic [W-1:0] quo_raw,
    input  logic [W-1:0] rem_fin,
    input  logic         zero_dvsr,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder,
    output logic         div_by_zero
);
    always_ff @(posedge clk) begin
        if (rst) begin
            quotient    <= '0;
            remainder   <= '0;
            div_by_zero <= 1'b0;
        end else if (finish) begin
            quotient    <= ~quo_raw;
            remainder   <= rem_fin;
            div_by_zero <= zero_dvsr;
        end
    end
endmodule

// File: rtl/seq_divider.sv
module seq_divider #(
    parameter int W = div_pkg::DIV_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder,
    output logic         div_by_zero
);
    localparam int CW = $clog2(W);

    logic         load, step, finish;
    logic [W-1:0] rem_q, quo_q, dvsr_q;
    logic [W-1:0] rem_nx, quo_nx;

    div_ctrl #(.W(W), .CW(CW)) u_ctrl (
        .clk(clk), .rst(rst), .start(start),
        .load(load), .step(step), .finish(finish),
        .busy(busy), .done(done)
    );

    div_step #(.W(W)) u_step (
        .rem_in(rem_q), .quo_in(quo_q), .dvsr(dvsr_q),
        .rem_out(rem_nx), .quo_out(quo_nx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q  <= '0;
            quo_q  <= '0;
            dvsr_q <= '0;
        end else if (load) begin
            rem_q  <= '0;
            quo_q  <= dividend;
            dvsr_q <= divisor;
        end else if (step) begin
            rem_q <= rem_nx;
            quo_q <= quo_nx;
        end
    end

    div_result #(.W(W)) u_res (
        .clk(clk), .rst(rst), .finish(finish),
        .quo_raw(quo_nx), .rem_fin(rem_nx), .zero_dvsr(dvsr_q == '0),
        .quotient(quotient), .remainder(remainder), .div_by_zero(div_by_zero)
    );
endmodule

// File: rtl/seq_divider_chk.sv
module seq_divider_chk #(
    parameter int W = div_pkg::DIV_W
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] quotient,
    input logic [W-1:0] remainder,
    input logic         div_by_zero
);
    // R3
    done_single_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
    // R3
    done_not_busy_chk: assert property (@(posedge clk) disable iff (rst) done |-> !busy);
    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (rst) (start && !busy) |=> busy);
    // R3
    busy_end_chk: assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> done);
    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(quotient) && $stable(remainder) && $stable(div_by_zero)));
    // R5
    zero_quot_chk: assert property (@(posedge clk) disable iff (rst)
        (done && div_by_zero) |-> (quotient == {W{1'b1}}));
endmodule

bind seq_divider seq_divider_chk #(.W(W)) u_chk (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .quotient(quotient), .remainder(remainder), .div_by_zero(div_by_zero)
);

// File: tb/seq_divider_bench.sv
module seq_divider_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] dividend = '0;
    logic [31:0] divisor = '0;
    logic        busy, done, div_by_zero;
    logic [31:0] quotient, remainder;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string phase = "R1";

    // behavioural reference state
    bit          m_busy = 0, m_done = 0, m_dz = 0;
    logic [31:0] m_q = '0, m_r = '0, m_a = '0, m_b = '0;
    int          remaining = 0;

    always #5 clk = ~clk;

    seq_divider u_seq_divider (
        .clk(clk), .rst(rst), .start(start), .dividend(dividend), .divisor(divisor),
        .busy(busy), .done(done), .quotient(quotient), .remainder(remainder),
        .div_by_zero(div_by_zero)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_done = 0; m_dz = 0; m_q = '0; m_r = '0; remaining = 0;
        end else begin
            m_done = 0;
            if (!m_busy && start) begin
                m_busy = 1; remaining = 32; m_a = dividend; m_b = divisor;
            end else if (m_busy) begin
                remaining = remaining - 1;
                if (remaining == 0) begin
                    m_busy = 0; m_done = 1;
                    m_dz = (m_b == 0);
                    m_q  = (m_b == 0) ? 32'hFFFF_FFFF : m_a / m_b;
                    m_r  = (m_b == 0) ? m_a : m_a % m_b;
                end
            end
        end
    end

    task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s (%s) %s: got %h expected %h at cycle %0d",
                     req, phase, what, got, exp, cycles);
        end
    endtask

    // compare every cycle away from the active edge
    always @(negedge clk) begin
        cycles++;
        if (rst) begin
            chk("R1", "busy", {31'b0, busy}, 32'd0);
            chk("R1", "done", {31'b0, done}, 32'd0);
            chk("R1", "quotient", quotient, 32'd0);
            chk("R1", "remainder", remainder, 32'd0);
            chk("R1", "div_by_zero", {31'b0, div_by_zero}, 32'd0);
        end else begin
            chk("R2", "busy", {31'b0, busy}, {31'b0, m_busy});
            chk("R3", "done", {31'b0, done}, {31'b0, m_done});
            chk("R4", "quotient", quotient, m_q);
            chk("R4", "remainder", remainder, m_r);
            chk("R5", "div_by_zero", {31'b0, div_by_zero}, {31'b0, m_dz});
        end
    end

    task automatic pulse(logic [31:0] a, logic [31:0] b);
        dividend = a; divisor = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
    endtask

    task automatic run(logic [31:0] a, logic [31:0] b);
        @(negedge clk);
        pulse(a, b);
        wait_done();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: first cycle after reset release is still idle and cleared
        @(negedge clk);
        phase = "R4";
        run(32'd100, 32'd7);
        run(32'd0, 32'd5);
        run(32'd1, 32'd1);
        run(32'hFFFF_FFFF, 32'd1);
        run(32'hFFFF_FFFF, 32'hFFFF_FFFF);
        run(32'd3, 32'd10);                 // divisor larger than dividend
        run(32'hFFFF_FFFF, 32'h8000_0001);  // divisor with top bit set
        run(32'h7FFF_FFFF, 32'h8000_0000);
        phase = "R5";
        run(32'h1234_5678, 32'd0);
        run(32'd0, 32'd0);
        run(32'hFFFF_FFFF, 32'd0);
        phase = "R4";
        for (int i = 0; i < 40; i++) run($urandom, $urandom);
        for (int i = 0; i < 20; i++) run($urandom, $urandom & 32'hFF);
        // R6: start while busy must not disturb the running division
        phase = "R6";
        @(negedge clk);
        pulse(32'd1000, 32'd3);
        repeat (5) @(negedge clk);
        pulse(32'd77, 32'd0);
        repeat (10) @(negedge clk);
        pulse(32'd5, 32'd5);
        wait_done();
        // R7 / R8: start in the done cycle, old results held during next run
        phase = "R7";
        pulse(32'd999, 32'd10);
        wait_done();
        phase = "R8";
        pulse(32'hDEAD_BEEF, 32'd0);
        wait_done();
        @(negedge clk);
        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not complete, got timeout expected finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule